// File: doc/BRIEF.md
# Line Frequency Clock Interrupter

This block produces a mains-rate time base for a processor. A down-counter clocked by the system clock toggles an internal square wave once per half period. The half period is the system clock rate divided by twice the selected line rate, 50 Hz or 60 Hz. Every rising edge of that wave latches a monitor flag in a 16-bit status register. Software reads the register and clears the flag by writing it.

Software also owns an interrupt-enable flag in the same register. An edge detector watches the AND of monitor and enable. It emits a one-cycle request pulse when that AND turns true and a one-cycle cancel pulse when it turns false, so a pending request can be withdrawn before it is serviced. A bus-init input restores the register without triggering the detector. A connect input gates the wave off entirely.

Top module: `line_clock_irq`

## Requirements
- R1: After reset or bus init, `reg_rdata` reads 0x0080 (monitor at bit 7 set, enable at bit 6 clear, every other bit 0), and neither `irq_req` nor `irq_cancel` is high.
- R2: A write (`reg_wr` high at a clock edge) loads bit 7 of `reg_wdata` into monitor and bit 6 into enable, so writing 0 to bit 7 clears monitor; the other written bits have no effect and read back as 0.
- R3: With `clk_connect` high, the square wave toggles every SYS_HZ/(2·f) cycles, and each of its rising edges sets monitor, so rising edges come SYS_HZ/f cycles apart (120 cycles at 50 Hz and 100 cycles at 60 Hz with the default SYS_HZ of 6000).
- R4: `freq_hz` equal to 50 or 60 selects that line rate, taking effect at the next half-period boundary; at reset 50 Hz is selected.
- R5: Any other `freq_hz` value is ignored and the previously selected rate is kept.
- R6: `irq_req` is high for exactly one cycle, the cycle after the clock edge at which monitor AND enable goes from 0 to 1, whether a write or a wave edge caused it.
- R7: `irq_cancel` is high for exactly one cycle, the cycle after the edge at which monitor AND enable goes from 1 to 0.
- R8: Bus init clears enable, sets monitor and resets the edge detector, so no cancel pulse follows init even when monitor AND enable was 1, and a later 0-to-1 change raises `irq_req` again.
- R9: While `clk_connect` is low, the wave is held low and monitor is never set by the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_init | input | 1 | Synchronous bus initialise |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 16 | Status register write data |
| reg_rdata | output | 16 | Status register read data |
| freq_hz | input | 8 | Requested line rate in Hz (50 or 60) |
| clk_connect | input | 1 | Connects the divider to the monitor flag |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| irq_cancel | output | 1 | One-cycle interrupt withdrawal pulse |

## Verification
The register, request and cancel results are all due one cycle after the write or init that causes them. The driver changes inputs at a falling edge and pushes one expected triple of request, cancel and read data. The monitor pops it at the next falling edge, after exactly one rising edge has updated the state. Divider timing is measured from the cycle in which a set monitor bit is first seen: the bench clears the flag at once and counts falling edges until the flag reappears. That count must equal the full period exactly, and a rate change made mid-period must give one period that is half old and half new.

// File: rtl/line_clock_irq.sv
module line_clock_irq #(
  parameter int SYS_HZ  = 6000,
  parameter int RATE_LO = 50,
  parameter int RATE_HI = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_init,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic [7:0]  freq_hz,
  input  logic        clk_connect,
  output logic        irq_req,
  output logic        irq_cancel
);
  localparam int HALF_LO = SYS_HZ / (2 * RATE_LO);
  localparam int HALF_HI = SYS_HZ / (2 * RATE_HI);
  localparam int CW      = $clog2(HALF_LO + 1);
  localparam int MON_BIT = 7;
  localparam int ENA_BIT = 6;

  logic [CW-1:0] cnt;
  logic sel_hi, wave, mon, ena, cond_q;

  wire tick      = (cnt == '0);
  wire sel_hi_nx = (freq_hz == 8'(RATE_HI)) ? 1'b1 :
                   (freq_hz == 8'(RATE_LO)) ? 1'b0 : sel_hi;
  wire rise      = tick & clk_connect & ~wave;
  wire cond      = mon & ena;
  wire unused_wd = ^{reg_wdata[15:8], reg_wdata[5:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= CW'(HALF_LO - 1);
      sel_hi <= 1'b0;
      wave   <= 1'b0;
    end else begin
      if (tick) begin
        sel_hi <= sel_hi_nx;
        cnt    <= sel_hi_nx ? CW'(HALF_HI - 1) : CW'(HALF_LO - 1);
      end else begin
        cnt <= cnt - 1'b1;
      end
      wave <= clk_connect & (tick ? ~wave : wave);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon    <= 1'b1;
      ena    <= 1'b0;
      cond_q <= 1'b0;
    end else if (bus_init) begin
      mon    <= 1'b1;
      ena    <= 1'b0;
      cond_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        mon <= reg_wdata[MON_BIT] | rise;
        ena <= reg_wdata[ENA_BIT];
      end else if (rise) begin
        mon <= 1'b1;
      end
      cond_q <= cond;
    end
  end

  assign irq_req    = cond & ~cond_q;
  assign irq_cancel = ~cond & cond_q;

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[MON_BIT] = mon;
    reg_rdata[ENA_BIT] = ena;
  end

  // R1
  init_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |=> (reg_rdata == 16'h0080 && !irq_req && !irq_cancel));

  // R2
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !bus_init && !rise) |=> (reg_rdata[7:6] == $past(reg_wdata[7:6])));

  // R5
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sel_hi));

  // R6
  req_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (reg_rdata[7:6] == 2'b11 && $past(reg_rdata[7:6]) != 2'b11));

  // R7
  cancel_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cancel |-> (reg_rdata[7:6] != 2'b11 && $past(reg_rdata[7:6]) == 2'b11));

  // R9
  disconnect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_connect |=> !wave);
endmodule

// File: tb/line_clock_irq_tb_top.sv
module line_clock_irq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_init = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  freq_hz = 8'd50;
  logic        clk_connect = 1'b1;
  logic        irq_req, irq_cancel;

  int tests = 0;
  int fails = 0;

  typedef struct { string r; logic [17:0] e; } item_t;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  line_clock_irq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .freq_hz(freq_hz),
    .clk_connect(clk_connect), .irq_req(irq_req), .irq_cancel(irq_cancel)
  );

  task automatic check(input string r, input logic [17:0] act, input logic [17:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      check(it.r, {irq_req, irq_cancel, reg_rdata}, it.e);
    end
  end

  task automatic step(input string r, input logic wr, input logic [15:0] d,
                      input logic ini, input logic [17:0] e);
    @(negedge clk);
    reg_wr = wr; reg_wdata = d; bus_init = ini;
    #1 sbq.push_back('{r, e});
  endtask

  // Clears monitor now and counts falling edges until it is seen set again.
  task automatic measure(output int n);
    reg_wr = 1'b1; reg_wdata = 16'h0000; bus_init = 1'b0;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      reg_wr = 1'b0;
      n++;
      if (reg_rdata[7]) break;
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1 reset state", 0, 16'h0, 0, {2'b00, 16'h0080});
    step("R1 reset state held", 0, 16'h0, 0, {2'b00, 16'h0080});
    @(negedge clk);
    measure(n);
    measure(n);
    check("R3 50 Hz period", 18'(n), 18'd120);
    // register and edge detector, all within a few cycles after a rise
    step("R2 write enable only", 1, 16'h0040, 0, {2'b00, 16'h0040});
    step("R2 other bits read 0", 1, 16'hFF3F, 0, {2'b00, 16'h0000});
    step("R6 write raises request", 1, 16'h00C0, 0, {2'b10, 16'h00C0});
    step("R6 request lasts one cycle", 0, 16'h0, 0, {2'b00, 16'h00C0});
    step("R7 clearing monitor cancels", 1, 16'h0040, 0, {2'b01, 16'h0040});
    step("R7 cancel lasts one cycle", 0, 16'h0, 0, {2'b00, 16'h0040});
    step("R6 request again", 1, 16'h00C0, 0, {2'b10, 16'h00C0});
    step("R8 init gives no cancel", 0, 16'h0, 1, {2'b00, 16'h0080});
    step("R8 init state held", 0, 16'h0, 0, {2'b00, 16'h0080});
    step("R8 request after init", 1, 16'h00C0, 0, {2'b10, 16'h00C0});
    step("R7 cancel via write", 1, 16'h0040, 0, {2'b01, 16'h0040});
    step("R2 idle keeps value", 0, 16'h0, 0, {2'b00, 16'h0040});
    // enable set, monitor clear: wait for the wave to raise a request
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if (reg_rdata[7]) break;
    end
    check("R6 wave edge raises request", {irq_req, irq_cancel, reg_rdata}, {2'b10, 16'h00C0});
    freq_hz = 8'd60;
    measure(n);
    check("R4 switch to 60 Hz mid period", 18'(n), 18'd110);
    measure(n);
    check("R4 60 Hz period", 18'(n), 18'd100);
    freq_hz = 8'd55;
    measure(n);
    check("R5 invalid rate ignored", 18'(n), 18'd100);
    freq_hz = 8'd0;
    measure(n);
    check("R5 zero rate ignored", 18'(n), 18'd100);
    freq_hz = 8'd50;
    measure(n);
    check("R4 switch back to 50 Hz", 18'(n), 18'd110);
    measure(n);
    check("R3 50 Hz period again", 18'(n), 18'd120);
    // disconnect
    clk_connect = 1'b0;
    step("R9 clear monitor", 1, 16'h0000, 0, {2'b00, 16'h0000});
    for (int i = 0; i < 300; i++)
      step("R9 no monitor while disconnected", 0, 16'h0, 0, {2'b00, 16'h0000});
    @(negedge clk);
    clk_connect = 1'b1;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if (reg_rdata[7]) break;
    end
    check("R9 reconnect sets monitor", 18'(n <= 61 ? 1 : 0), 18'd1);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule